// File: doc/BRIEF.md
# Fractional Dither Engine for an 8-bit DAC Code

This block lets a DAC with a coarse integer code produce set points that fall between its steps. A host stores a whole-step code and a fractional byte. Each time the external update strobe pulses, the fraction is added to a wrapping phase accumulator. The carry from that addition raises the registered output code by one step for that update only.

Over many updates, the output dwells on the higher code for a share of updates equal to the fraction divided by 256. Because the extra step comes from the accumulator carry, the higher code is spread as evenly as it can be. A half step therefore alternates on every update, which keeps the ripple frequency high for the analog low-pass filter that follows. The host's values are held in shadow registers and are only used at an update strobe. When the base code is at full scale, the output clamps there instead of wrapping.

Top module: `dither_dac_engine`

## Requirements
- R1: A synchronous reset, active high, sets the output code to 0 and clears the phase accumulator. After reset, with base n and fraction 0x80, the first update gives n and the second gives n+1.
- R2: A host write (`wr_en` high) stores `wr_base` and `wr_frac`. It does not change `dac_code` by itself. The stored values are applied at the next update strobe.
- R3: In a cycle where `upd_tick` is low, the accumulator and `dac_code` hold their values.
- R4: On an update strobe, the 8-bit accumulator adds the fraction modulo 256. One clock edge later, `dac_code` equals base plus the carry out of that addition.
- R5: A fraction of 0 never produces a carry, so `dac_code` equals the base on every update.
- R6: For a base below 255, any 256 consecutive updates with a fixed fraction f put out base+1 exactly f times.
- R7: From a cleared accumulator, fraction 0x80 alternates base, base+1 on every update. Fraction 0x40 repeats base, base, base, base+1. Fraction 0xC0 repeats base, base+1, base+1, base+1.
- R8: With a base of 255, a carry leaves `dac_code` at 255 and does not wrap to 0.
- R9: A write in the same cycle as an update strobe does not affect that update. The new values first apply at the following strobe.
- R10: A host write does not clear the accumulator. The carry pattern continues from the accumulator's current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for the two setting bytes |
| wr_base | input | 8 | Integer DAC code to store |
| wr_frac | input | 8 | Fractional dither byte to store |
| upd_tick | input | 1 | Single-cycle update strobe from the rate timer |
| dac_code | output | 8 | Registered code for the DAC |

## Verification
The properties assume that `upd_tick` is a clean synchronous level sampled on each edge. They also assume that reset is held for at least one edge before the first strobe. They compare the new code only with the shadow values that were present at the strobe. The stimulus drives every input half a period away from the active edge. It asserts reset before any other activity and mixes random writes and strobes, including writes that land in the same cycle as a strobe, so every combination the properties cover appears without breaking those assumptions.

// File: rtl/dd_pkg.sv
package dd_pkg;
    localparam int DD_CODE_W = 8;
    localparam int DD_FRAC_W = 8;
endpackage

// File: rtl/dd_host_regs.sv
module dd_host_regs #(
    parameter int CODE_W = dd_pkg::DD_CODE_W,
    parameter int FRAC_W = dd_pkg::DD_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_base,
    input  logic [FRAC_W-1:0] wr_frac,
    output logic [CODE_W-1:0] base_q,
    output logic [FRAC_W-1:0] frac_q
);
    typedef struct packed {
        logic [CODE_W-1:0] base;
        logic [FRAC_W-1:0] frac;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            sh_d.base = wr_base;
            sh_d.frac = wr_frac;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign base_q = sh_q.base;
    assign frac_q = sh_q.frac;
endmodule

// File: rtl/dd_phase_acc.sv
module dd_phase_acc #(
    parameter int FRAC_W = dd_pkg::DD_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_tick,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic [FRAC_W-1:0] phase
);
    localparam int SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, st_q.acc} + {1'b0, frac};
        st_d  = st_q;
        carry = 1'b0;
        if (upd_tick) begin
            st_d.acc = sum[FRAC_W-1:0];
            carry    = sum[FRAC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase = st_q.acc;
endmodule

// File: rtl/dd_code_sat.sv
module dd_code_sat #(
    parameter int CODE_W = dd_pkg::DD_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_tick,
    input  logic [CODE_W-1:0] base,
    input  logic              carry,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       at_top;

    always_comb begin
        at_top = (base == CODE_MAX);
        st_d   = st_q;
        if (upd_tick) begin
            if (carry && !at_top) st_d.code = base + CODE_W'(1);
            else                  st_d.code = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code = st_q.code;
endmodule

// File: rtl/dither_dac_engine.sv
module dither_dac_engine #(
    parameter int CODE_W = dd_pkg::DD_CODE_W,
    parameter int FRAC_W = dd_pkg::DD_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_base,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              upd_tick,
    output logic [CODE_W-1:0] dac_code
);
    logic [CODE_W-1:0] base_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W-1:0] acc_phase;
    logic              acc_carry;

    dd_host_regs #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_base(wr_base), .wr_frac(wr_frac),
        .base_q(base_q), .frac_q(frac_q)
    );

    dd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst(rst), .upd_tick(upd_tick),
        .frac(frac_q), .carry(acc_carry), .phase(acc_phase)
    );

    dd_code_sat #(.CODE_W(CODE_W)) u_out (
        .clk(clk), .rst(rst), .upd_tick(upd_tick),
        .base(base_q), .carry(acc_carry), .code(dac_code)
    );
endmodule

// File: rtl/dd_engine_chk.sv
module dd_engine_chk #(
    parameter int CODE_W = dd_pkg::DD_CODE_W,
    parameter int FRAC_W = dd_pkg::DD_FRAC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_tick,
    input logic [CODE_W-1:0] base_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic              carry,
    input logic [CODE_W-1:0] dac_code
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    // R1: reset drives the code to zero
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> dac_code == '0);

    // R3: no strobe, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !upd_tick |=> $stable(dac_code));

    // R3: no carry appears without a strobe
    p_idle_carry_r3: assert property (@(posedge clk) disable iff (rst)
        !upd_tick |-> !carry);

    // R4: new code is the stored base or one above it
    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        upd_tick |=> ({1'b0, dac_code} == {1'b0, $past(base_q)}) ||
                     ({1'b0, dac_code} == {1'b0, $past(base_q)} + 1'b1));

    // R5: zero fraction keeps the base
    p_zero_frac_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && frac_q == '0) |=> dac_code == $past(base_q));

    // R8: full scale clamps
    p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && base_q == CODE_MAX) |=> dac_code == CODE_MAX);
endmodule

bind dither_dac_engine dd_engine_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .upd_tick(upd_tick),
    .base_q(base_q), .frac_q(frac_q), .carry(acc_carry), .dac_code(dac_code)
);

// File: tb/dither_dac_engine_bench.sv
`timescale 1ns/1ps
module dither_dac_engine_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_base = '0;
    logic [7:0] wr_frac = '0;
    logic       upd_tick = 1'b0;
    logic [7:0] dac_code;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    logic [7:0] m_acc, m_base, m_frac, m_code;

    always #2 clk = ~clk;

    dither_dac_engine u_dither_dac_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_base(wr_base),
        .wr_frac(wr_frac), .upd_tick(upd_tick), .dac_code(dac_code)
    );

    function automatic bit exp_carry(input logic [7:0] acc, input logic [7:0] f);
        return ({1'b0, acc} + {1'b0, f}) > 9'd255;
    endfunction

    function automatic logic [7:0] exp_code(input logic [7:0] b, input bit c);
        if (b == 8'hFF) return 8'hFF;
        return b + {7'd0, c};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, clock once, update model, return at next negedge
    task automatic cyc(input bit w, input logic [7:0] b, input logic [7:0] f, input bit t);
        bit c;
        wr_en = w; wr_base = b; wr_frac = f; upd_tick = t;
        @(posedge clk);
        if (t) begin
            c      = exp_carry(m_acc, m_frac);
            m_acc  = m_acc + m_frac;
            m_code = exp_code(m_base, c);
        end
        if (w) begin
            m_base = b;
            m_frac = f;
        end
        @(negedge clk);
        wr_en = 1'b0; upd_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(0, 8'h00, 8'h00, 0);
        rst = 1'b0;
        m_acc = '0; m_base = '0; m_frac = '0; m_code = '0;
    endtask

    task automatic tick_chk(input string req);
        cyc(0, 8'h00, 8'h00, 1);
        check(req, dac_code, m_code);
    endtask

    initial begin
        int cnt;
        logic [7:0] b;
        void'($urandom(32'h5EED));
        @(negedge clk);
        do_reset();
        check("R1 reset code", dac_code, 8'h00);

        // R2: write alone changes nothing
        cyc(1, 8'h37, 8'h00, 0);
        check("R2 write no effect", dac_code, 8'h00);
        tick_chk("R2 applied at tick");
        check("R2 value", dac_code, 8'h37);

        // R3: hold between strobes
        for (int i = 0; i < 5; i++) begin
            cyc(0, 8'h00, 8'h00, 0);
            check("R3 hold", dac_code, 8'h37);
        end

        // R1: accumulator cleared
        do_reset();
        cyc(1, 8'd10, 8'h80, 0);
        tick_chk("R1 first update");
        check("R1 first n", dac_code, 8'd10);
        tick_chk("R1 second update");
        check("R1 second n+1", dac_code, 8'd11);

        // R7 patterns
        do_reset();
        cyc(1, 8'd50, 8'h80, 0);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 8'h00, 8'h00, 1);
            check("R7 half", dac_code, (i % 2 == 1) ? 8'd51 : 8'd50);
        end
        do_reset();
        cyc(1, 8'd50, 8'h40, 0);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 8'h00, 8'h00, 1);
            check("R7 quarter", dac_code, (i % 4 == 3) ? 8'd51 : 8'd50);
        end
        do_reset();
        cyc(1, 8'd50, 8'hC0, 0);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 8'h00, 8'h00, 1);
            check("R7 three quarter", dac_code, (i % 4 == 0) ? 8'd50 : 8'd51);
        end

        // R5: zero fraction
        for (int i = 0; i < 20; i++) begin
            b = 8'($urandom_range(0, 255));
            cyc(1, b, 8'h00, 0);
            cyc(0, 8'h00, 8'h00, 1);
            check("R5 zero frac", dac_code, b);
        end

        // R8: saturation
        cyc(1, 8'hFF, 8'hC0, 0);
        for (int i = 0; i < 12; i++) begin
            cyc(0, 8'h00, 8'h00, 1);
            check("R8 saturate", dac_code, 8'hFF);
        end

        // R9: write coinciding with tick
        do_reset();
        cyc(1, 8'd20, 8'h00, 0);
        cyc(1, 8'd90, 8'h00, 1);
        check("R9 old value used", dac_code, 8'd20);
        tick_chk("R9 new value next");
        check("R9 new value", dac_code, 8'd90);

        // R10: write keeps phase
        do_reset();
        cyc(1, 8'd5, 8'h80, 0);
        tick_chk("R10 pre");
        cyc(1, 8'd7, 8'h80, 0);
        tick_chk("R10 phase kept");
        check("R10 carry after write", dac_code, 8'd8);

        // R6: every fraction over 256 updates
        for (int f = 0; f < 256; f++) begin
            b = 8'($urandom_range(0, 254));
            cyc(1, b, 8'(f), 0);
            cnt = 0;
            for (int k = 0; k < 256; k++) begin
                cyc(0, 8'h00, 8'h00, 1);
                if (dac_code == b + 8'd1) cnt++;
                if (dac_code !== m_code) check("R4 sweep", dac_code, m_code);
            end
            tests++;
            if (cnt != f) begin
                fails++;
                $display("FAIL R6 frac %0h: got %0d high codes expected %0d", f, cnt, f);
            end
        end

        // R4: random mix against the model
        for (int i = 0; i < 3000; i++) begin
            bit w, t;
            w = ($urandom_range(0, 9) == 0);
            t = ($urandom_range(0, 2) != 0);
            cyc(w, 8'($urandom), 8'($urandom), t);
            check("R4 random", dac_code, m_code);
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule